// File: doc/BRIEF.md
# Four-Phase Request/Acknowledge Bus Link

This block joins a bus master controller and a bus slave controller over a fully interlocked request/acknowledge link that carries an address, a direction bit and a data word. The two sides share no timing contract. Each one sees the other's handshake line only through its own two-flop synchronizer, so the protocol is correct for any relative delay between them. The master is assumed to already own the bus. It takes one command at a time from its local side. It places the address and direction on the bus, and also the data for a write. It then holds them for a settling interval so the slave can decode before request rises.

The slave responds only to addresses inside its window. For a write it hands the address and data to its local store as a one-cycle write strobe and raises acknowledge. For a read it fetches a word from its local store, places it on the data lines and raises acknowledge. After seeing acknowledge, the master drops request and keeps any read word. The slave drops acknowledge once request has fallen. The master then pulses done and may start the next command. If no slave answers, the master gives up after a timeout and reports an error on its done pulse.

Top module: `fp_handshake_pair`

## Requirements
- R1: While reset is held, request, acknowledge, done, the write strobe and the slave data drive are all low, and the master reports ready.
- R2: A command is taken only when the master is ready. Address, direction and write data appear on the bus one cycle after acceptance. Request rises exactly SETTLE_CYC cycles after the accepting edge (2 by default).
- R3: For a write, the slave raises acknowledge three cycles after request rises. In that same cycle it gives a one-cycle local write strobe carrying the low SPAN address bits and the bus data.
- R4: For a read, the slave drives its local word onto the data lines exactly while its acknowledge is high. At no other time does it drive them.
- R5: The master drops request three cycles after acknowledge rises. For a read it keeps the word on the data lines at that edge.
- R6: The slave drops acknowledge three cycles after request falls, never while request is high. Request never rises while acknowledge is high.
- R7: Done is a one-cycle pulse three cycles after acknowledge falls. It carries error = 0 and, for a read, the kept word. The master is ready again from that cycle.
- R8: An address whose bits above SPAN differ from those of SLV_BASE (0x40 by default, SPAN = 4) gets no acknowledge, no strobe and no drive. Request falls TIMEOUT_CYC cycles after it rose, and done with error = 1 follows one cycle later.
- R9: The master drives the data lines only for a write, from the cycle after acceptance until done. Master and slave never drive them together. Undriven lines read as zero.
- R10: A command presented while the master is busy is ignored. The bus address stays at the accepted value until done, and only one done pulse occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both controller models |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Local command present at the master |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW | Target address |
| cmd_wdata | input | DW | Write word |
| cmd_ready | output | 1 | Master idle and able to accept |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Set with done when no slave answered |
| rdata | output | DW | Read word returned with done |
| loc_wr_en | output | 1 | Slave local write strobe |
| loc_addr | output | SPAN | Slave local word offset |
| loc_wdata | output | DW | Slave local write word |
| loc_rdata | input | DW | Slave local read word at loc_addr |
| bus_req | output | 1 | Request line (master driven) |
| bus_ack | output | 1 | Acknowledge line (slave driven) |
| bus_addr | output | AW | Address lines |
| bus_wr | output | 1 | Direction line |
| bus_data | output | DW | Resolved data lines |
| slv_drive | output | 1 | Slave currently drives the data lines |

## Verification
Counted from the accepting edge with the default settling delay, request is due after 2 edges. The slave's acknowledge and write strobe follow after 5, request falls after 8, acknowledge falls after 11, and done arrives after 14. A timed-out command reports done after SETTLE_CYC + TIMEOUT_CYC + 1 edges. The bench's reference model derives each expected line value from these offsets. It samples every output on the falling edge after each rising edge, so each comparison sees the value registered at the edge just counted. Write data is confirmed at the strobe cycle and again by reading it back through the link later.

// File: rtl/fp_pkg.sv
package fp_pkg;

    typedef enum logic [1:0] {
        M_IDLE    = 2'd0,
        M_SETTLE  = 2'd1,
        M_REQ     = 2'd2,
        M_RELEASE = 2'd3
    } mst_state_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_ACK  = 1'b1
    } slv_state_e;

endpackage

// File: rtl/fp_sync.sv
module fp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/fp_master.sv
module fp_master
    import fp_pkg::*;
#(
    parameter int AW          = 8,
    parameter int DW          = 16,
    parameter int SETTLE_CYC  = 2,
    parameter int TIMEOUT_CYC = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_write,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    output logic          cmd_ready,
    output logic          done,
    output logic          done_err,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] bus_addr,
    output logic          bus_wr,
    output logic          bus_req,
    output logic          mst_oe,
    output logic [DW-1:0] mst_wdata,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_data
);
    localparam int CMAX = (SETTLE_CYC > TIMEOUT_CYC) ? SETTLE_CYC : TIMEOUT_CYC;
    localparam int CW   = $clog2(CMAX + 1);

    typedef struct packed {
        mst_state_e    st;
        logic [AW-1:0] addr;
        logic          wr;
        logic [DW-1:0] wdata;
        logic          req;
        logic [CW-1:0] cnt;
        logic          done;
        logic          err;
        logic [DW-1:0] rdata;
    } mst_regs_t;

    mst_regs_t r_d, r_q;
    logic      ack_s;

    fp_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_ack),
        .q     (ack_s)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            M_IDLE: begin
                if (cmd_valid) begin
                    r_d.addr  = cmd_addr;
                    r_d.wr    = cmd_write;
                    r_d.wdata = cmd_wdata;
                    r_d.err   = 1'b0;
                    r_d.cnt   = CW'(SETTLE_CYC);
                    r_d.st    = M_SETTLE;
                end
            end
            M_SETTLE: begin
                if (r_q.cnt <= CW'(1)) begin
                    r_d.req = 1'b1;
                    r_d.cnt = '0;
                    r_d.st  = M_REQ;
                end else begin
                    r_d.cnt = r_q.cnt - CW'(1);
                end
            end
            M_REQ: begin
                if (ack_s) begin
                    r_d.req = 1'b0;
                    if (!r_q.wr) r_d.rdata = bus_data;
                    r_d.st  = M_RELEASE;
                end else if (r_q.cnt == CW'(TIMEOUT_CYC - 1)) begin
                    r_d.req = 1'b0;
                    r_d.err = 1'b1;
                    r_d.st  = M_RELEASE;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            M_RELEASE: begin
                if (!ack_s) begin
                    r_d.done = 1'b1;
                    r_d.st   = M_IDLE;
                end
            end
            default: r_d.st = M_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: M_IDLE, addr: '0, wr: 1'b0, wdata: '0, req: 1'b0,
                     cnt: '0, done: 1'b0, err: 1'b0, rdata: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_ready = (r_q.st == M_IDLE);
    assign done      = r_q.done;
    assign done_err  = r_q.err;
    assign rdata     = r_q.rdata;
    assign bus_addr  = r_q.addr;
    assign bus_wr    = r_q.wr;
    assign bus_req   = r_q.req;
    assign mst_oe    = (r_q.st != M_IDLE) && r_q.wr;
    assign mst_wdata = r_q.wdata;
endmodule

// File: rtl/fp_slave.sv
module fp_slave
    import fp_pkg::*;
#(
    parameter int          AW          = 8,
    parameter int          DW          = 16,
    parameter int          SPAN        = 4,
    parameter int unsigned SLV_BASE    = 'h40,
    parameter int          SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_req,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic [DW-1:0]   bus_data,
    output logic            bus_ack,
    output logic            slv_drive,
    output logic [DW-1:0]   slv_data,
    output logic            loc_wr_en,
    output logic [SPAN-1:0] loc_addr,
    output logic [DW-1:0]   loc_wdata,
    input  logic [DW-1:0]   loc_rdata
);
    localparam logic [AW-1:0] BASE_V = AW'(SLV_BASE);

    typedef struct packed {
        slv_state_e    st;
        logic          ack;
        logic          drive;
        logic [DW-1:0] rdat;
        logic          wr_en;
        logic [DW-1:0] wdata;
    } slv_regs_t;

    slv_regs_t r_d, r_q;
    logic      req_s;
    logic      hit;

    fp_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_req),
        .q     (req_s)
    );

    assign hit = (bus_addr[AW-1:SPAN] == BASE_V[AW-1:SPAN]);

    always_comb begin
        r_d       = r_q;
        r_d.wr_en = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                if (req_s && hit) begin
                    r_d.ack = 1'b1;
                    r_d.st  = S_ACK;
                    if (bus_wr) begin
                        r_d.wr_en = 1'b1;
                        r_d.wdata = bus_data;
                    end else begin
                        r_d.drive = 1'b1;
                        r_d.rdat  = loc_rdata;
                    end
                end
            end
            S_ACK: begin
                if (!req_s) begin
                    r_d.ack   = 1'b0;
                    r_d.drive = 1'b0;
                    r_d.st    = S_IDLE;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, ack: 1'b0, drive: 1'b0, rdat: '0,
                     wr_en: 1'b0, wdata: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_ack   = r_q.ack;
    assign slv_drive = r_q.drive;
    assign slv_data  = r_q.rdat;
    assign loc_wr_en = r_q.wr_en;
    assign loc_addr  = bus_addr[SPAN-1:0];
    assign loc_wdata = r_q.wdata;
endmodule

// File: rtl/fp_handshake_pair.sv
module fp_handshake_pair #(
    parameter int          AW          = 8,
    parameter int          DW          = 16,
    parameter int          SPAN        = 4,
    parameter int unsigned SLV_BASE    = 'h40,
    parameter int          SETTLE_CYC  = 2,
    parameter int          TIMEOUT_CYC = 64,
    parameter int          SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic            cmd_write,
    input  logic [AW-1:0]   cmd_addr,
    input  logic [DW-1:0]   cmd_wdata,
    output logic            cmd_ready,
    output logic            done,
    output logic            done_err,
    output logic [DW-1:0]   rdata,
    output logic            loc_wr_en,
    output logic [SPAN-1:0] loc_addr,
    output logic [DW-1:0]   loc_wdata,
    input  logic [DW-1:0]   loc_rdata,
    output logic            bus_req,
    output logic            bus_ack,
    output logic [AW-1:0]   bus_addr,
    output logic            bus_wr,
    output logic [DW-1:0]   bus_data,
    output logic            slv_drive
);
    logic          mst_oe;
    logic [DW-1:0] mst_wdata;
    logic [DW-1:0] slv_data;

    fp_master #(
        .AW(AW), .DW(DW), .SETTLE_CYC(SETTLE_CYC),
        .TIMEOUT_CYC(TIMEOUT_CYC), .SYNC_STAGES(SYNC_STAGES)
    ) u_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_write (cmd_write),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .cmd_ready (cmd_ready),
        .done      (done),
        .done_err  (done_err),
        .rdata     (rdata),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_req   (bus_req),
        .mst_oe    (mst_oe),
        .mst_wdata (mst_wdata),
        .bus_ack   (bus_ack),
        .bus_data  (bus_data)
    );

    fp_slave #(
        .AW(AW), .DW(DW), .SPAN(SPAN), .SLV_BASE(SLV_BASE),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (bus_req),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_data  (bus_data),
        .bus_ack   (bus_ack),
        .slv_drive (slv_drive),
        .slv_data  (slv_data),
        .loc_wr_en (loc_wr_en),
        .loc_addr  (loc_addr),
        .loc_wdata (loc_wdata),
        .loc_rdata (loc_rdata)
    );

    // Resolved shared data lines: whichever side is enabled, else zero.
    always_comb begin
        if (slv_drive)   bus_data = slv_data;
        else if (mst_oe) bus_data = mst_wdata;
        else             bus_data = '0;
    end
endmodule

// File: rtl/fp_handshake_chk.sv
module fp_handshake_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_req,
    input logic          bus_ack,
    input logic [AW-1:0] bus_addr,
    input logic          bus_wr,
    input logic          slv_drive,
    input logic          mst_oe,
    input logic          loc_wr_en,
    input logic          done
);
    // R1
    a_r1_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |=> (!bus_req && !bus_ack && !done && !slv_drive && !loc_wr_en));

    // R2 / R10
    a_r10_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && $past(bus_req)) |-> $stable(bus_addr));

    // R3
    a_r3_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ack) |-> bus_req);

    a_r3_strobe_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        loc_wr_en |-> (bus_wr && $rose(bus_ack)));

    // R4
    a_r4_drive_only_read_ack: assert property (@(posedge clk) disable iff (!rst_n)
        slv_drive |-> (bus_ack && !bus_wr));

    // R6
    a_r6_ack_falls_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_ack) |-> !bus_req);

    a_r6_req_rises_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> !bus_ack);

    // R7
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    a_r9_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !(slv_drive && mst_oe));
endmodule

bind fp_handshake_pair fp_handshake_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_ack   (bus_ack),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .slv_drive (slv_drive),
    .mst_oe    (mst_oe),
    .loc_wr_en (loc_wr_en),
    .done      (done)
);

// File: tb/fp_handshake_pair_test.sv
module fp_handshake_pair_test;
    localparam int S  = 2;
    localparam int T  = 64;
    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_write = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          cmd_ready, done, done_err;
    logic [DW-1:0] rdata;
    logic          loc_wr_en;
    logic [3:0]    loc_addr;
    logic [DW-1:0] loc_wdata, loc_rdata;
    logic          bus_req, bus_ack, bus_wr, slv_drive;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_data;

    logic [DW-1:0] store [16];
    logic [DW-1:0] shadow [16];
    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    fp_handshake_pair uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
        .done(done), .done_err(done_err), .rdata(rdata), .loc_wr_en(loc_wr_en),
        .loc_addr(loc_addr), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
        .bus_req(bus_req), .bus_ack(bus_ack), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_data(bus_data), .slv_drive(slv_drive)
    );

    assign loc_rdata = store[loc_addr];
    always @(posedge clk) if (loc_wr_en) store[loc_addr] <= loc_wdata;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model: expected line values k edges after the accepting edge.
    task automatic run_txn(input bit wr, input logic [AW-1:0] a,
                           input logic [DW-1:0] wd, input bit poke);
        bit hit;
        int last;
        logic [DW-1:0] exp_rd;
        bit e_req, e_ack, e_drv;
        logic [DW-1:0] e_data;
        hit    = (a[7:4] == 4'h4);
        last   = hit ? S + 12 : S + T + 1;
        exp_rd = shadow[a[3:0]];
        @(negedge clk);
        chk("R2 ready before command", 32'(cmd_ready), 32'd1);
        cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = wd;
        @(posedge clk);
        for (int k = 0; k <= last; k++) begin
            @(negedge clk);
            if (k == 0) cmd_valid = 1'b0;
            if (poke && k == 4) begin
                cmd_valid = 1'b1; cmd_write = ~wr; cmd_addr = a ^ 8'h05;
                cmd_wdata = ~wd;
            end
            if (poke && k == 9) cmd_valid = 1'b0;
            if (hit) begin
                e_req = (k >= S) && (k < S + 6);
                e_ack = (k >= S + 3) && (k < S + 9);
            end else begin
                e_req = (k >= S) && (k < S + T);
                e_ack = 1'b0;
            end
            e_drv = !wr && e_ack;
            if (e_drv)                 e_data = exp_rd;
            else if (wr && k < last)   e_data = wd;
            else                       e_data = '0;
            chk(k < S + 6 ? "R2 request line" : (hit ? "R5 request fall" : "R8 request timeout"),
                32'(bus_req), 32'(e_req));
            chk(k < S + 9 ? "R3 acknowledge line" : "R6 acknowledge fall",
                32'(bus_ack), 32'(e_ack));
            chk("R4 slave drive", 32'(slv_drive), 32'(e_drv));
            chk("R9 data lines", 32'(bus_data), 32'(e_data));
            chk("R3 write strobe", 32'(loc_wr_en), 32'(wr && hit && k == S + 3));
            if (wr && hit && k == S + 3) begin
                chk("R3 strobe offset", 32'(loc_addr), 32'(a[3:0]));
                chk("R3 strobe word", 32'(loc_wdata), 32'(wd));
            end
            chk(poke ? "R10 address held while busy" : "R2 address on bus",
                32'(bus_addr), 32'(a));
            chk("R2 direction on bus", 32'(bus_wr), 32'(wr));
            chk(poke ? "R10 single done" : "R7 done pulse", 32'(done), 32'(k == last));
            chk("R7 ready timing", 32'(cmd_ready), 32'(k == last));
            if (k == last) begin
                chk(hit ? "R7 done error clear" : "R8 done error set",
                    32'(done_err), 32'(!hit));
                if (hit && !wr) chk("R5 read word returned", 32'(rdata), 32'(exp_rd));
            end
        end
        if (wr && hit) shadow[a[3:0]] = wd;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            store[i]  = 16'h5A00 + 16'(i * 3);
            shadow[i] = 16'h5A00 + 16'(i * 3);
        end
        repeat (3) @(negedge clk);
        chk("R1 request in reset", 32'(bus_req), 32'd0);
        chk("R1 acknowledge in reset", 32'(bus_ack), 32'd0);
        chk("R1 done in reset", 32'(done), 32'd0);
        chk("R1 drive in reset", 32'(slv_drive), 32'd0);
        chk("R1 strobe in reset", 32'(loc_wr_en), 32'd0);
        chk("R1 ready in reset", 32'(cmd_ready), 32'd1);
        rst_n = 1'b1;

        run_txn(1'b0, 8'h43, 16'h0000, 1'b0);   // read of initial content
        run_txn(1'b1, 8'h40, 16'hBEEF, 1'b0);   // lowest offset
        run_txn(1'b1, 8'h4F, 16'h1234, 1'b0);   // highest offset
        run_txn(1'b1, 8'h47, 16'hFFFF, 1'b0);
        run_txn(1'b0, 8'h40, 16'h0000, 1'b0);   // read-back
        run_txn(1'b0, 8'h4F, 16'h0000, 1'b0);
        run_txn(1'b0, 8'h47, 16'h0000, 1'b0);
        run_txn(1'b1, 8'h80, 16'hDEAD, 1'b0);   // R8 write miss
        run_txn(1'b0, 8'h3F, 16'h0000, 1'b0);   // R8 read miss
        run_txn(1'b0, 8'h4F, 16'h0000, 1'b0);   // miss left store intact
        run_txn(1'b1, 8'h4A, 16'h0F0F, 1'b1);   // R10 poke during write
        run_txn(1'b0, 8'h4A, 16'h0000, 1'b1);   // R10 poke during read
        run_txn(1'b0, 8'h4F, 16'h0000, 1'b0);   // poke wrote nothing

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule